// File: doc/BRIEF.md
# Bit-Slip Word Boundary Aligner

This block sits behind a deserializer and lets the logic downstream move the word boundary of the parallel stream by hand. The stream arrives as words of `W` bits, with bit 0 of each word the earliest received. The block keeps the word that came before the current one. Each output word is a `W`-bit window over the pair of words, and a slip offset picks where that window starts. Logic that searches for its own framing pattern asks for one slip at a time until the words come out framed the way it wants.

A slip moves the boundary one bit later in the stream. The earliest bit in the window is dropped for good. A slip request counts only once it has been high for two consecutive clock edges, and it produces one slip however long it stays high. After `W` slips the offset wraps back to zero. The block makes no pattern search and has no lock or sync indication.

Top module: `bitslip_aligner`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `out_data` become 0, the slip offset becomes 0 and the stored previous word becomes 0. The first output word after reset, at offset 0, is therefore all zeros.
- R2: At offset 0, each output word equals the input word accepted one valid beat earlier. The output lags the input by one word.
- R3: `out_valid` is high in the cycle after a cycle in which `in_valid` was high, and low in the cycle after a cycle in which it was low.
- R4: `out_data` keeps its value in a cycle that follows a cycle with `in_valid` low.
- R5: The offset goes up by one when `slip_req` is sampled high at two consecutive clock edges and was low at the edge before them. A request held for many cycles gives exactly one slip.
- R6: A `slip_req` pulse that is high at only one clock edge leaves the offset unchanged.
- R7: At offset k, the output word is bits [k+W-1:k] of the 2W-bit value {current input word, previous input word}. Bit 0 is the earliest received, so the k earliest bits of the previous word are dropped.
- R8: The offset counts modulo `W`. After `W` slips the framing is back to the framing at offset 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | W | Parallel word from the deserializer, bit 0 earliest |
| in_valid | input | 1 | `in_data` carries a word this cycle |
| slip_req | input | 1 | Slip request, level held for two or more cycles |
| out_data | output | W | Realigned word |
| out_valid | output | 1 | `out_data` was updated in this cycle |

## Verification
On every cycle the assertions check the following:
- the valid latency;
- that the output holds when no word was accepted;
- that the offset only ever steps by one with wrap at `W`;
- that any offset step was preceded by two edges of a high request.

Only the bench scenarios can show the following:
- the word contents at every offset;
- that a one-cycle pulse and a long hold each give the right number of slips;
- that a full round of slips restores the original framing.

// File: rtl/bitslip_aligner.sv
module bitslip_aligner #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  input  logic         slip_req,
  output logic [W-1:0] out_data,
  output logic         out_valid
);
  localparam int OW = (W > 1) ? $clog2(W) : 1;
  localparam logic [OW-1:0] OFF_LAST = OW'(W - 1);

  logic [W-1:0]   prev_q;
  logic [OW-1:0]  off_q;
  logic           req_d1, req_d2;
  logic           slip_fire;
  logic [2*W-1:0] window;

  assign slip_fire = slip_req & req_d1 & ~req_d2;
  assign window    = {in_data, prev_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q    <= '0;
      off_q     <= '0;
      req_d1    <= 1'b0;
      req_d2    <= 1'b0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      req_d1    <= slip_req;
      req_d2    <= req_d1;
      out_valid <= in_valid;
      if (slip_fire)
        off_q <= (off_q == OFF_LAST) ? '0 : off_q + 1'b1;
      if (in_valid) begin
        prev_q   <= in_data;
        out_data <= window[off_q +: W];
      end
    end
  end
endmodule

module bitslip_aligner_chk #(
  parameter int W  = 8,
  parameter int OW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          slip_req,
  input logic          out_valid,
  input logic [W-1:0]  out_data,
  input logic [OW-1:0] off_q
);
  AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> out_valid == $past(in_valid)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> $stable(out_data)); // R4
  AST_OFF_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && off_q != $past(off_q)) |->
      off_q == (($past(off_q) == OW'(W - 1)) ? '0 : $past(off_q) + 1'b1)); // R8
  AST_SLIP_QUAL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && off_q != $past(off_q)) |->
      ($past(slip_req) && $past(slip_req, 2))); // R5
  AST_OFF_RANGE: assert property (@(posedge clk) disable iff (rst)
    32'(off_q) < W); // R7
endmodule

bind bitslip_aligner bitslip_aligner_chk #(.W(W), .OW(OW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .slip_req(slip_req),
  .out_valid(out_valid), .out_data(out_data), .off_q(off_q)
);

// File: tb/bitslip_aligner_bench.sv
module bitslip_aligner_bench;
  localparam int W = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] in_data = '0;
  logic         in_valid = 1'b0;
  logic         slip_req = 1'b0;
  logic [W-1:0] out_data;
  logic         out_valid;

  int checks = 0;
  int errors = 0;
  int off = 0;
  logic [W-1:0] prev = '0;
  logic [W-1:0] seed = 6'h2b;

  always #2 clk = ~clk;

  bitslip_aligner #(.W(W)) u_bitslip_aligner (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .slip_req(slip_req), .out_data(out_data), .out_valid(out_valid)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [W-1:0] w, input string tag);
    logic [2*W-1:0] cat;
    logic [W-1:0]   exp;
    string          t;
    cat = {w, prev};
    exp = W'(cat >> off);
    t = (tag != "") ? tag : ((off == 0) ? "R2" : "R7");
    @(negedge clk);
    in_data  = w;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R3 valid", W'(out_valid), W'(1));
    check(t, out_data, exp);
    prev = w;
    @(negedge clk);
    check("R3 idle", W'(out_valid), W'(0));
    check("R4", out_data, exp);
  endtask

  task automatic slip(input int len);
    @(negedge clk);
    slip_req = 1'b1;
    repeat (len) @(negedge clk);
    slip_req = 1'b0;
    repeat (2) @(negedge clk);
    if (len >= 2) off = (off + 1) % W;
  endtask

  function automatic logic [W-1:0] next_word(input logic [W-1:0] s);
    return W'((s * 13 + 7) % (1 << W));
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 valid", W'(out_valid), W'(0));
    check("R1 data", out_data, '0);
    push(6'h3f, "R1 prev");
    push(6'h01, "");
    push(6'h20, "");
    for (int round = 0; round < W; round++) begin
      slip((round % 2 == 0) ? 2 : 3);
      for (int i = 0; i < 4; i++) begin
        seed = next_word(seed);
        push(seed, "");
      end
      push(6'h01, "");
      push(6'h20, "");
    end
    push(6'h15, "R8");
    push(6'h2a, "R8");
    slip(1);
    push(6'h33, "R6");
    push(6'h0c, "R6");
    slip(12);
    push(6'h33, "R5");
    push(6'h0c, "R5");
    slip(2);
    for (int i = 0; i < 6; i++) begin
      seed = next_word(seed);
      push(seed, "R7");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule